// File: doc/BRIEF.md
# Shared-Slave Priority Arbiter

This block decides which of up to twelve bus masters owns a single shared slave port. Every master drives a request line and has a 2-bit priority. When the port is free, or the current owner reaches a break point, the arbiter picks the highest-priority requester. Ties between masters of equal priority are settled round-robin, starting just after the master that last won. Only the grant decision is made here. Address and data steering belong to the fabric around it.

An owner keeps the port until one of three things happens: a transfer beat flagged as the last beat or a split point, its request falling, or the slot-cycle budget running out. The budget caps how many cycles one master may keep the port while others wait. When no master is requesting, a parking policy sets who stays connected. The choices are nobody, the most recent owner, or a configured fixed master. A master that is already parked sees its grant at once. In the disconnected case a new requester waits one cycle.

Index 7 is a hole in the master numbering. It is never granted.

Top module: `bus_slave_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, `grant_o` is all zero and `grant_idx_o` is 0.
- R2: At an arbitration point, the new owner is a requester with the largest 2-bit priority value. A larger value beats a smaller one.
- R3: Among requesters that share the top priority, the search starts at the index after the last real owner and wraps around. Before any grant the search starts at index 0.
- R4: An active owner that still requests keeps the grant on every cycle without a beat, and on every beat whose last/split flag is low (subject to R5). A beat with the flag high re-arbitrates. So does a fall of the owner's request.
- R5: With a slot limit L (1 to 511) and a beat on every cycle, an owner holds the grant for exactly L cycles and then loses it to a waiting requester. The budget reloads on every new grant.
- R6: A slot limit of 0 never ends a grant.
- R7: Parking mode 0 (none) and mode 3 (reserved) leave `grant_o` at zero when nobody requests. A request then shows its grant one cycle later.
- R8: Parking mode 1 (last) keeps the last real owner granted while idle. Its renewed request sees the grant with no extra cycle. Before any real grant, nothing is parked.
- R9: Parking mode 2 (fixed) grants the master named by the 4-bit fixed field while idle. A value of 7 or a value of 12 or more parks nobody.
- R10: Index 7 is never granted, and its request is ignored.
- R11: A parked master that is not requesting never delays another requester. That requester gets the grant on the next cycle.
- R12: `grant_o` has at most one bit set. `grant_idx_o` equals the position of that bit, or 0 when no bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 12 | Per-master request lines |
| prio_i | input | 24 | Per-master 2-bit priority, master k at bits 2k+1:2k |
| slot_limit_i | input | 9 | Maximum grant length in cycles; 0 disables the limit |
| park_mode_i | input | 2 | Idle policy: 0 none, 1 last owner, 2 fixed master, 3 reserved (as 0) |
| park_fixed_i | input | 4 | Master index used by fixed parking |
| beat_i | input | 1 | Owner completes a transfer beat this cycle |
| last_i | input | 1 | That beat is the last of its burst or a split point |
| grant_o | output | 12 | One-hot grant, registered |
| grant_idx_o | output | 4 | Index of the granted master, registered |

## Verification
Some properties are checked by assertions on every cycle:
- the grant is one-hot-or-zero and agrees with the index;
- the hole at index 7 stays empty;
- the picked master is a requester with no lower priority than any other requester;
- an owner without a beat keeps the grant;
- a zero limit never breaks a grant;
- an idle cycle with no parking clears the grant.

Other behaviours need sequences and are shown only by the bench's scenarios:
- the exact round-robin order;
- a grant that lasts exactly L cycles;
- zero-latency access by a parked master;
- the rejection of invalid fixed indices.

The bench shows these with directed runs and with a long randomized sweep against an arithmetic model.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_RSVD  = 2'd3
  } park_mode_e;

endpackage

// File: rtl/bus_arb_pick.sv
// Highest-priority pick with round-robin tie break after a pointer.
module bus_arb_pick #(
  parameter int N  = 12,
  parameter int PW = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    cand_i,
  input  logic [N*PW-1:0] prio_i,
  input  logic [IW-1:0]   ptr_i,
  output logic            pick_valid_o,
  output logic [IW-1:0]   pick_idx_o
);

  logic [PW-1:0] prio_a [N];
  logic [PW-1:0] top_prio;
  logic [N-1:0]  elig;

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign prio_a[g] = prio_i[g*PW +: PW];
  end

  always_comb begin
    top_prio = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (prio_a[i] > top_prio)) top_prio = prio_a[i];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_elig
    assign elig[g] = cand_i[g] && (prio_a[g] == top_prio);
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    pick_idx_o = '0;
    for (int off = 1; off <= N; off++) begin
      if (!found && elig[(int'(ptr_i) + off) % N]) begin
        found      = 1'b1;
        pick_idx_o = IW'((int'(ptr_i) + off) % N);
      end
    end
    pick_valid_o = found;
  end

  // The chosen master requests and no requester outranks it.
  p_pick_cand_r10: assert property (@(posedge clk) disable iff (rst)
    pick_valid_o |-> cand_i[pick_idx_o]);

  for (genvar g = 0; g < N; g++) begin : g_chk
    p_prio_win_r2: assert property (@(posedge clk) disable iff (rst)
      (pick_valid_o && cand_i[g]) |-> (prio_a[pick_idx_o] >= prio_a[g]));
  end

endmodule

// File: rtl/bus_arb_slot.sv
// Grant-length budget: counts owned cycles and flags when the limit is due.
module bus_arb_slot #(
  parameter int SW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart_i,
  input  logic          run_i,
  input  logic [SW-1:0] limit_i,
  output logic          expired_o
);

  localparam logic [SW-1:0] CNT_MAX = '1;

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (run_i && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = (limit_i != '0) &&
                     (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i});

  // A fresh grant with a budget above one cycle is never due at once.
  p_fresh_budget_r5: assert property (@(posedge clk) disable iff (rst)
    (restart_i && (limit_i > 1)) |=> (!expired_o || !$stable(limit_i)));

  // A zero limit never signals expiry.
  p_no_limit_r6: assert property (@(posedge clk) disable iff (rst)
    (limit_i == '0) |-> !expired_o);

endmodule

// File: rtl/bus_arb_park.sv
// Idle parking target selection.
module bus_arb_park
  import bus_arb_pkg::*;
#(
  parameter int N = 12,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  parameter logic [N-1:0] VALID = '1
) (
  input  logic [1:0]    mode_i,
  input  logic [IW-1:0] fixed_i,
  input  logic [IW-1:0] last_idx_i,
  input  logic          last_valid_i,
  output logic          park_valid_o,
  output logic [IW-1:0] park_idx_o
);

  localparam int SPAN = 2 ** IW;
  localparam logic [SPAN-1:0] VALID_W = SPAN'(VALID);

  park_mode_e mode;
  assign mode = park_mode_e'(mode_i);

  always_comb begin
    park_valid_o = 1'b0;
    park_idx_o   = '0;
    unique case (mode)
      PARK_LAST: begin
        park_valid_o = last_valid_i;
        park_idx_o   = last_valid_i ? last_idx_i : '0;
      end
      PARK_FIXED: begin
        park_valid_o = VALID_W[fixed_i];
        park_idx_o   = VALID_W[fixed_i] ? fixed_i : '0;
      end
      default: begin
        park_valid_o = 1'b0;
        park_idx_o   = '0;
      end
    endcase
  end

endmodule

// File: rtl/bus_slave_arbiter.sv
// Shared-slave arbiter: priority + round robin, slot budget, idle parking.
module bus_slave_arbiter
  import bus_arb_pkg::*;
#(
  parameter int N_MASTERS = 12,
  parameter int PRIO_W    = 2,
  parameter int SLOT_W    = 9,
  localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
  parameter logic [N_MASTERS-1:0] HOLE_MASK = N_MASTERS'(12'h080)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_MASTERS-1:0]        req_i,
  input  logic [N_MASTERS*PRIO_W-1:0] prio_i,
  input  logic [SLOT_W-1:0]           slot_limit_i,
  input  logic [1:0]                  park_mode_i,
  input  logic [IDX_W-1:0]            park_fixed_i,
  input  logic                        beat_i,
  input  logic                        last_i,
  output logic [N_MASTERS-1:0]        grant_o,
  output logic [IDX_W-1:0]            grant_idx_o
);

  localparam logic [N_MASTERS-1:0] VALID = ~HOLE_MASK;
  localparam int SPAN = 2 ** IDX_W;
  localparam logic [IDX_W-1:0] PTR_INIT = IDX_W'(N_MASTERS - 1);

  logic [N_MASTERS-1:0] grant_q, grant_d;
  logic [IDX_W-1:0]     owner_q, owner_d;
  logic                 active_q, active_d;
  logic [IDX_W-1:0]     ptr_q;
  logic                 ptr_valid_q;

  logic [N_MASTERS-1:0] cand;
  logic [SPAN-1:0]      req_w;
  logic                 owner_req;
  logic                 slot_exp;
  logic                 arb_pt;
  logic                 pick_valid, park_valid;
  logic [IDX_W-1:0]     pick_idx, park_idx;
  logic                 sel_valid;
  logic [IDX_W-1:0]     sel_idx;

  assign cand      = req_i & VALID;
  assign req_w     = SPAN'(req_i);
  assign owner_req = req_w[owner_q];
  assign arb_pt    = !active_q || !owner_req || (beat_i && (last_i || slot_exp));

  bus_arb_pick #(.N(N_MASTERS), .PW(PRIO_W)) u_pick (
    .clk          (clk),
    .rst          (rst),
    .cand_i       (cand),
    .prio_i       (prio_i),
    .ptr_i        (ptr_q),
    .pick_valid_o (pick_valid),
    .pick_idx_o   (pick_idx)
  );

  bus_arb_slot #(.SW(SLOT_W)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .restart_i (arb_pt && pick_valid),
    .run_i     (active_q),
    .limit_i   (slot_limit_i),
    .expired_o (slot_exp)
  );

  bus_arb_park #(.N(N_MASTERS), .VALID(VALID)) u_park (
    .mode_i       (park_mode_i),
    .fixed_i      (park_fixed_i),
    .last_idx_i   (ptr_q),
    .last_valid_i (ptr_valid_q),
    .park_valid_o (park_valid),
    .park_idx_o   (park_idx)
  );

  always_comb begin
    if (pick_valid) begin
      sel_valid = 1'b1;
      sel_idx   = pick_idx;
    end else begin
      sel_valid = park_valid;
      sel_idx   = park_idx;
    end
  end

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_onehot
    assign grant_d[g] = sel_valid && (sel_idx == IDX_W'(g));
  end

  always_comb begin
    if (arb_pt) begin
      active_d = pick_valid;
      owner_d  = sel_valid ? sel_idx : '0;
    end else begin
      active_d = active_q;
      owner_d  = owner_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q     <= '0;
      owner_q     <= '0;
      active_q    <= 1'b0;
      ptr_q       <= PTR_INIT;
      ptr_valid_q <= 1'b0;
    end else begin
      active_q <= active_d;
      owner_q  <= owner_d;
      if (arb_pt) grant_q <= grant_d;
      if (arb_pt && pick_valid) begin
        ptr_q       <= pick_idx;
        ptr_valid_q <= 1'b1;
      end
    end
  end

  assign grant_o     = grant_q;
  assign grant_idx_o = owner_q;

  p_grant_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  p_idx_match_r12: assert property (@(posedge clk) disable iff (rst)
    (grant_o != '0) |-> grant_o[grant_idx_o]);

  p_hole_empty_r10: assert property (@(posedge clk) disable iff (rst)
    (grant_o & HOLE_MASK) == '0);

  p_hold_no_beat_r4: assert property (@(posedge clk) disable iff (rst)
    (active_q && owner_req && !beat_i) |=> ($stable(grant_o) && $stable(grant_idx_o)));

  p_unlimited_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (active_q && owner_req && !last_i && (slot_limit_i == '0)) |=> $stable(grant_o));

  p_idle_none_r7: assert property (@(posedge clk) disable iff (rst)
    (arb_pt && (cand == '0) && ((park_mode_i == PARK_NONE) || (park_mode_i == PARK_RSVD)))
    |=> (grant_o == '0));

endmodule

// File: tb/bus_slave_arbiter_tb.sv
`timescale 1ns/1ps
module bus_slave_arbiter_tb;

  localparam int N = 12;
  localparam logic [N-1:0] VALIDM = 12'hF7F;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic [2*N-1:0] prio = '0;
  logic [8:0]    lim = '0;
  logic [1:0]    mode = 2'd0;
  logic [3:0]    fixd = 4'd0;
  logic          beat = 1'b0;
  logic          lastb = 1'b0;
  logic [N-1:0]  grant_o;
  logic [3:0]    grant_idx_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  int m_owner = 0, m_ptr = N-1, m_cnt = 0;
  bit m_gv = 0, m_active = 0, m_pv = 0;

  always #2 clk = ~clk;

  bus_slave_arbiter u_dut (
    .clk(clk), .rst(rst), .req_i(req), .prio_i(prio), .slot_limit_i(lim),
    .park_mode_i(mode), .park_fixed_i(fixd), .beat_i(beat), .last_i(lastb),
    .grant_o(grant_o), .grant_idx_o(grant_idx_o)
  );

  task automatic chk(input string tag, input bit gv, input int idx);
    logic [N-1:0] eg;
    logic [3:0]   ei;
    eg = gv ? (N'(1) << idx) : '0;
    ei = gv ? 4'(idx) : 4'd0;
    checks++;
    if (grant_o !== eg || grant_idx_o !== ei) begin
      fails++;
      $display("FAIL %s: actual grant=%h idx=%0d, expected grant=%h idx=%0d",
               tag, grant_o, grant_idx_o, eg, ei);
    end
  endtask

  task automatic model_step();
    logic [N-1:0] cand;
    bit own_req, expd, arb;
    int top, win;
    cand    = req & VALIDM;
    own_req = m_active && req[m_owner];
    expd    = (lim != 0) && (m_cnt + 1 >= int'(lim));
    arb     = !m_active || !own_req || (beat && (lastb || expd));
    if (arb) begin
      if (cand != 0) begin
        top = 0;
        for (int i = 0; i < N; i++)
          if (cand[i] && int'(prio[2*i +: 2]) > top) top = int'(prio[2*i +: 2]);
        win = -1;
        for (int off = 1; off <= N; off++) begin
          int j;
          j = (m_ptr + off) % N;
          if (win < 0 && cand[j] && int'(prio[2*j +: 2]) == top) win = j;
        end
        m_owner = win; m_gv = 1; m_active = 1; m_ptr = win; m_pv = 1; m_cnt = 0;
      end else begin
        m_active = 0; m_gv = 0; m_owner = 0;
        if (mode == 2'd1 && m_pv) begin
          m_gv = 1; m_owner = m_ptr;
        end else if (mode == 2'd2 && fixd < N && VALIDM[fixd]) begin
          m_gv = 1; m_owner = int'(fixd);
        end
      end
    end else if (m_cnt != 511) begin
      m_cnt++;
    end
  endtask

  // one clock: model, edge, then compare against model
  task automatic cyc();
    model_step();
    @(posedge clk);
    #1;
    chk("R2,R3,R4,R5 model", m_gv, m_owner);
  endtask

  task automatic set_prio(input int idx, input int val);
    prio[2*idx +: 2] = 2'(val);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1..all: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int seq5 [7] = '{5, 5, 5, 3, 3, 3, 5};
    repeat (3) @(posedge clk);
    #1;
    chk("R1 in reset", 0, 0);
    rst = 1'b0;
    mode = 2'd1;
    @(posedge clk); #1;
    chk("R1 after reset", 0, 0);
    // nothing parked before a real grant (R8)
    cyc();
    chk("R8 no prior owner", 0, 0);

    // R7: mode none, one cycle of latency
    mode = 2'd0; beat = 1; lastb = 0;
    req = 12'h004;
    #1 chk("R7 not yet granted", 0, 0);
    cyc();
    chk("R7 grant after one cycle", 1, 2);
    req = '0;
    cyc();
    chk("R7 released to none", 0, 0);

    // R2: priority
    set_prio(1, 1); set_prio(4, 3); set_prio(9, 2);
    req = 12'h212; lastb = 1;
    cyc();
    chk("R2 highest priority", 1, 4);
    req = '0;
    cyc();

    // R3: round robin among equals
    set_prio(3, 2); set_prio(5, 2); set_prio(10, 2);
    req = 12'h428;
    cyc(); chk("R3 rr first", 1, 5);
    cyc(); chk("R3 rr second", 1, 10);
    cyc(); chk("R3 rr wrap", 1, 3);
    cyc(); chk("R3 rr again", 1, 5);

    // R4 / R6: hold
    req = 12'h028; beat = 0; lastb = 0;
    for (int k = 0; k < 4; k++) begin
      cyc(); chk("R4 hold without beat", 1, 5);
    end
    beat = 1;
    for (int k = 0; k < 3; k++) begin
      cyc(); chk("R6 zero limit holds", 1, 5);
    end
    lastb = 1;
    cyc(); chk("R4 last beat rearbitrates", 1, 3);

    // R5: slot limit
    req = '0; lastb = 0;
    cyc();
    lim = 9'd3; req = 12'h028;
    for (int k = 0; k < 7; k++) begin
      cyc(); chk("R5 slot sequence", 1, seq5[k]);
    end

    // R8: park on last
    req = '0; mode = 2'd1; lim = '0;
    cyc(); chk("R8 parked on last", 1, 5);
    req = 12'h020;
    #1 chk("R8 zero latency", 1, 5);
    cyc(); chk("R8 keeps owner", 1, 5);

    // R11: parked master does not block
    req = '0;
    cyc(); chk("R11 parked", 1, 5);
    set_prio(8, 0);
    req = 12'h100;
    cyc(); chk("R11 other requester wins", 1, 8);

    // R9: fixed parking
    req = '0; mode = 2'd2; fixd = 4'd9;
    cyc(); chk("R9 fixed park", 1, 9);
    fixd = 4'd7;
    cyc(); chk("R9 hole index parks none", 0, 0);
    fixd = 4'd13;
    cyc(); chk("R9 out of range parks none", 0, 0);

    // R10: hole index ignored
    mode = 2'd0; set_prio(7, 3); set_prio(0, 0);
    req = 12'h080;
    cyc(); chk("R10 hole request ignored", 0, 0);
    req = 12'h081;
    cyc(); chk("R10 lower real requester wins", 1, 0);

    // R7: reserved mode acts as none
    req = '0; mode = 2'd3;
    cyc(); chk("R7 reserved mode", 0, 0);

    // sweep against the model (R12 encoding checked each cycle)
    for (int c = 0; c < 3000; c++) begin
      if (c % 150 == 0) begin
        int lsel;
        mode = 2'($urandom_range(0, 3));
        fixd = 4'($urandom_range(0, 15));
        lsel = $urandom_range(0, 4);
        lim  = (lsel == 0) ? 9'd0 : (lsel == 1) ? 9'd1 : (lsel == 2) ? 9'd2 :
               (lsel == 3) ? 9'd4 : 9'd7;
        prio = 24'($urandom);
      end
      req   = ($urandom_range(0, 5) == 0) ? '0 : 12'($urandom) & 12'($urandom);
      beat  = ($urandom_range(0, 3) != 0);
      lastb = ($urandom_range(0, 2) == 0);
      cyc();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule